// File: doc/BRIEF.md
# Multi-block transfer address sequencer

This block keeps the per-block state of one DMA channel: a source address, a destination address, a control word and a block size. When a block finishes, it chooses the state for the next block and starts that block. Each side, source and destination, has its own 2-bit reload policy. Contiguous continues from the end address of the block just done. Reload returns to the address captured at enable. Shadow takes a staged register value. Linked takes a descriptor fetched over a request/acknowledge port. The block does not move data, drive the bus or read descriptors from memory.

Software enables the channel with a legal pair of policies. While the channel runs, software may rewrite the policy bits. Once neither side uses shadow or linked mode and both policies read contiguous when a block ends, that block was the last one and the sequencer reports completion. When the next block needs staged data that is not yet valid, the sequencer stalls and raises a wait flag. It does not start a block with stale values. Contiguous on both sides at enable time is rejected with an error flag.

Top module: `mblk_seq`

## Requirements
- R1: While reset is held, and directly after it, `blockStart`, `xferDone`, `cfgErr`, `waitValid` and `llReq` are 0, and the current address, control and size outputs are 0.
- R2: When `chanEn` rises with a legal policy pair, the next cycle shows a one-cycle `blockStart`. The current outputs then equal the initial inputs that were present at the enable edge.
- R3: Policy code 2'b00 (contiguous) on a side sets that side's next address to its block end address plus one, modulo 2^ADDR_W. The new address and `blockStart` appear in the cycle after the `blockDone` edge.
- R4: Policy code 2'b01 (reload) sets that side's next address to the value captured at enable. Changing the initial-address inputs after enable has no effect on it.
- R5: Policy code 2'b10 (shadow) loads that side's address from its shadow input when `shValid` is 1. If some side uses shadow and no side uses linked mode, control and size come from the shadow inputs.
- R6: If a shadow block end meets `shValid` = 0, the sequencer gives no `blockStart` and raises `waitValid` in the next cycle. It keeps the current outputs until `shValid` is 1. At that edge it loads, pulses `blockStart` and drops `waitValid`.
- R7: Policy code 2'b11 (linked) raises `llReq` in the cycle after the block end and holds it until `llAck`. An acknowledge with `llValid` = 1 loads that side's address, plus control and size, from the descriptor inputs and pulses `blockStart`. Linked takes precedence over shadow for control and size.
- R8: An acknowledge with `llValid` = 0 raises `waitValid` and keeps `llReq` high. The sequencer starts no block until a later acknowledge carries `llValid` = 1.
- R9: When both sides use contiguous or reload, the control and size outputs are restored to the values captured at enable at every block end.
- R10: A block end with both policies at 2'b00 gives a one-cycle `xferDone` and no `blockStart`. Later `blockDone` strobes do not change any output until the channel is re-enabled.
- R11: Enabling with both policies at 2'b00 sets `cfgErr` in the next cycle and keeps it set while `chanEn` stays high. No `blockStart` is given and `blockDone` is ignored.
- R12: Dropping `chanEn` abandons any pending block. By the next cycle `llReq`, `waitValid` and `cfgErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanEn | input | 1 | Channel enable level |
| srcType | input | 2 | Source reload policy: 00 contiguous, 01 reload, 10 shadow, 11 linked |
| dstType | input | 2 | Destination reload policy, same codes |
| initSrcAddr | input | ADDR_W | Initial source address, captured at enable |
| initDstAddr | input | ADDR_W | Initial destination address, captured at enable |
| initCtl | input | CTL_W | Initial control word, captured at enable |
| initSize | input | SIZE_W | Initial block size, captured at enable |
| blockDone | input | 1 | Strobe: the current block has finished |
| srcEndAddr | input | ADDR_W | Source end address of the finished block, valid with blockDone |
| dstEndAddr | input | ADDR_W | Destination end address of the finished block, valid with blockDone |
| shValid | input | 1 | Shadow values are valid |
| shSrcAddr | input | ADDR_W | Shadow source address |
| shDstAddr | input | ADDR_W | Shadow destination address |
| shCtl | input | CTL_W | Shadow control word |
| shSize | input | SIZE_W | Shadow block size |
| llReq | output | 1 | Descriptor request, held until llAck |
| llAck | input | 1 | Descriptor response strobe |
| llValid | input | 1 | Descriptor is valid, sampled with llAck |
| llSrcAddr | input | ADDR_W | Descriptor source address |
| llDstAddr | input | ADDR_W | Descriptor destination address |
| llCtl | input | CTL_W | Descriptor control word |
| llSize | input | SIZE_W | Descriptor block size |
| curSrcAddr | output | ADDR_W | Source address of the current block |
| curDstAddr | output | ADDR_W | Destination address of the current block |
| curCtl | output | CTL_W | Control word of the current block |
| curSize | output | SIZE_W | Block size of the current block |
| blockStart | output | 1 | One-cycle pulse: a block starts with the current outputs |
| xferDone | output | 1 | One-cycle pulse: the transfer has completed |
| cfgErr | output | 1 | Illegal policy pair at enable |
| waitValid | output | 1 | Stalled on invalid shadow or descriptor data |

## Verification
The checker watches several rules on every cycle. It checks the one-cycle contiguous address step (end plus one), the completion pulse that replaces a start when both policies read contiguous, and the error flag on an all-contiguous enable together with its suppression of starts. It also checks that a descriptor request is held until it is acknowledged and that no start occurs while stalled or when completing. Only the bench scenarios can show the rest, because the checker does not observe that state. That includes the reload value captured at enable surviving later changes to the inputs, the source priority for control and size, and the address wrap at the top of the range. It also includes the exact resume after a stall, the ignoring of strobes after completion, and the clean abandon when the channel is disabled.

// File: rtl/mblk_pkg.sv
`timescale 1ns/1ps
package mblk_pkg;

  typedef enum logic [1:0] {
    KIND_CONTIG = 2'b00,
    KIND_RELOAD = 2'b01,
    KIND_SHADOW = 2'b10,
    KIND_LINKED = 2'b11
  } sideKind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_PEND = 3'd2,
    ST_DONE = 3'd3,
    ST_ERR  = 3'd4
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      loadInit;  // capture initial values, make them current
    logic      latchEnd;  // hold the block end addresses
    logic      loadNext;  // move to next-block values
    sideKind_t srcKind;   // policy in force for the source side
    sideKind_t dstKind;   // policy in force for the destination side
  } seqStrobe_t;

endpackage

// File: rtl/mblk_dp.sv
`timescale 1ns/1ps
module mblk_dp import mblk_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CTL_W  = 16,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  input  logic [ADDR_W-1:0] initAddr [2],
  input  logic [ADDR_W-1:0] endAddr  [2],
  input  logic [ADDR_W-1:0] shAddr   [2],
  input  logic [ADDR_W-1:0] llAddr   [2],
  input  logic [CTL_W-1:0]  initCtlIn,
  input  logic [CTL_W-1:0]  shCtl,
  input  logic [CTL_W-1:0]  llCtl,
  input  logic [SIZE_W-1:0] initSizeIn,
  input  logic [SIZE_W-1:0] shSize,
  input  logic [SIZE_W-1:0] llSize,
  output logic [ADDR_W-1:0] curAddr  [2],
  output logic [CTL_W-1:0]  curCtl,
  output logic [SIZE_W-1:0] curSize
);

  localparam int SIDES = 2;

  sideKind_t kindOf [SIDES];
  assign kindOf[0] = st.srcKind;
  assign kindOf[1] = st.dstKind;

  // Per-side address state: captured base, held end address, current value
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [ADDR_W-1:0] baseQ, endQ, curQ, endUse, nextAddr;

    assign endUse = st.latchEnd ? endAddr[s] : endQ;

    always_comb begin
      unique case (kindOf[s])
        KIND_CONTIG: nextAddr = endUse + ADDR_W'(1);
        KIND_RELOAD: nextAddr = baseQ;
        KIND_SHADOW: nextAddr = shAddr[s];
        default:     nextAddr = llAddr[s];
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        endQ  <= '0;
        curQ  <= '0;
      end else begin
        if (st.loadInit) begin
          baseQ <= initAddr[s];
          curQ  <= initAddr[s];
        end else if (st.loadNext) begin
          curQ <= nextAddr;
        end
        if (st.latchEnd) endQ <= endAddr[s];
      end
    end

    assign curAddr[s] = curQ;
  end

  // Control and size: linked beats shadow beats captured initial values
  logic anyLinked, anyShadow;
  assign anyLinked = (st.srcKind == KIND_LINKED) || (st.dstKind == KIND_LINKED);
  assign anyShadow = (st.srcKind == KIND_SHADOW) || (st.dstKind == KIND_SHADOW);

  logic [CTL_W-1:0]  baseCtlQ, ctlQ, ctlNext;
  logic [SIZE_W-1:0] baseSizeQ, sizeQ, sizeNext;

  always_comb begin
    if (anyLinked) begin
      ctlNext  = llCtl;
      sizeNext = llSize;
    end else if (anyShadow) begin
      ctlNext  = shCtl;
      sizeNext = shSize;
    end else begin
      ctlNext  = baseCtlQ;
      sizeNext = baseSizeQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCtlQ  <= '0;
      baseSizeQ <= '0;
      ctlQ      <= '0;
      sizeQ     <= '0;
    end else if (st.loadInit) begin
      baseCtlQ  <= initCtlIn;
      baseSizeQ <= initSizeIn;
      ctlQ      <= initCtlIn;
      sizeQ     <= initSizeIn;
    end else if (st.loadNext) begin
      ctlQ  <= ctlNext;
      sizeQ <= sizeNext;
    end
  end

  assign curCtl  = ctlQ;
  assign curSize = sizeQ;

endmodule

// File: rtl/mblk_ctl.sv
`timescale 1ns/1ps
module mblk_ctl import mblk_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  sideKind_t  srcType,
  input  sideKind_t  dstType,
  input  logic       blockDone,
  input  logic       shValid,
  input  logic       llAck,
  input  logic       llValid,
  output seqStrobe_t st,
  output logic       blockStart,
  output logic       xferDone,
  output logic       cfgErr,
  output logic       waitValid,
  output logic       llReq,
  output logic       inRun
);

  seqState_t stateQ, stateD;
  sideKind_t srcKq, dstKq, effSrc, effDst;
  logic      startD, doneD, waitSet, waitD;
  logic      effLinked, effShadow, liveBothContig;

  // In RUN the live policy bits decide; once pending, the latched ones do
  assign effSrc    = (stateQ == ST_RUN) ? srcType : srcKq;
  assign effDst    = (stateQ == ST_RUN) ? dstType : dstKq;
  assign effLinked = (effSrc == KIND_LINKED) || (effDst == KIND_LINKED);
  assign effShadow = (effSrc == KIND_SHADOW) || (effDst == KIND_SHADOW);
  assign liveBothContig = (srcType == KIND_CONTIG) && (dstType == KIND_CONTIG);

  always_comb begin
    stateD     = stateQ;
    startD     = 1'b0;
    doneD      = 1'b0;
    waitSet    = 1'b0;
    st.loadInit = 1'b0;
    st.latchEnd = 1'b0;
    st.loadNext = 1'b0;
    st.srcKind  = effSrc;
    st.dstKind  = effDst;

    unique case (stateQ)
      ST_IDLE: begin
        if (chanEn) begin
          if (liveBothContig) begin
            stateD = ST_ERR;
          end else begin
            st.loadInit = 1'b1;
            startD      = 1'b1;
            stateD      = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (blockDone) begin
          st.latchEnd = 1'b1;
          if (liveBothContig) begin
            doneD  = 1'b1;
            stateD = ST_DONE;
          end else if (effLinked) begin
            stateD = ST_PEND;
          end else if (effShadow && !shValid) begin
            waitSet = 1'b1;
            stateD  = ST_PEND;
          end else begin
            st.loadNext = 1'b1;
            startD      = 1'b1;
          end
        end
      end
      ST_PEND: begin
        if (effLinked) begin
          if (llAck) begin
            if (llValid) begin
              st.loadNext = 1'b1;
              startD      = 1'b1;
              stateD      = ST_RUN;
            end else begin
              waitSet = 1'b1;
            end
          end
        end else if (shValid) begin
          st.loadNext = 1'b1;
          startD      = 1'b1;
          stateD      = ST_RUN;
        end else begin
          waitSet = 1'b1;
        end
      end
      default: ;
    endcase

    if (!chanEn) begin
      stateD      = ST_IDLE;
      startD      = 1'b0;
      doneD       = 1'b0;
      waitSet     = 1'b0;
      st.loadInit = 1'b0;
      st.latchEnd = 1'b0;
      st.loadNext = 1'b0;
    end
  end

  assign waitD = (stateD == ST_PEND) && (waitValid || waitSet);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      srcKq      <= KIND_CONTIG;
      dstKq      <= KIND_CONTIG;
      blockStart <= 1'b0;
      xferDone   <= 1'b0;
      cfgErr     <= 1'b0;
      waitValid  <= 1'b0;
    end else begin
      stateQ     <= stateD;
      blockStart <= startD;
      xferDone   <= doneD;
      cfgErr     <= (stateD == ST_ERR);
      waitValid  <= waitD;
      if (st.latchEnd) begin
        srcKq <= srcType;
        dstKq <= dstType;
      end
    end
  end

  assign llReq = (stateQ == ST_PEND) && effLinked;
  assign inRun = (stateQ == ST_RUN);

endmodule

// File: rtl/mblk_seq.sv
`timescale 1ns/1ps
module mblk_seq import mblk_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CTL_W  = 16,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic [1:0]        srcType,
  input  logic [1:0]        dstType,
  input  logic [ADDR_W-1:0] initSrcAddr,
  input  logic [ADDR_W-1:0] initDstAddr,
  input  logic [CTL_W-1:0]  initCtl,
  input  logic [SIZE_W-1:0] initSize,
  input  logic              blockDone,
  input  logic [ADDR_W-1:0] srcEndAddr,
  input  logic [ADDR_W-1:0] dstEndAddr,
  input  logic              shValid,
  input  logic [ADDR_W-1:0] shSrcAddr,
  input  logic [ADDR_W-1:0] shDstAddr,
  input  logic [CTL_W-1:0]  shCtl,
  input  logic [SIZE_W-1:0] shSize,
  output logic              llReq,
  input  logic              llAck,
  input  logic              llValid,
  input  logic [ADDR_W-1:0] llSrcAddr,
  input  logic [ADDR_W-1:0] llDstAddr,
  input  logic [CTL_W-1:0]  llCtl,
  input  logic [SIZE_W-1:0] llSize,
  output logic [ADDR_W-1:0] curSrcAddr,
  output logic [ADDR_W-1:0] curDstAddr,
  output logic [CTL_W-1:0]  curCtl,
  output logic [SIZE_W-1:0] curSize,
  output logic              blockStart,
  output logic              xferDone,
  output logic              cfgErr,
  output logic              waitValid
);

  seqStrobe_t        strobe;
  logic              inRun;
  logic [ADDR_W-1:0] initA [2];
  logic [ADDR_W-1:0] endA  [2];
  logic [ADDR_W-1:0] shA   [2];
  logic [ADDR_W-1:0] llA   [2];
  logic [ADDR_W-1:0] curA  [2];

  assign initA[0] = initSrcAddr;
  assign initA[1] = initDstAddr;
  assign endA[0]  = srcEndAddr;
  assign endA[1]  = dstEndAddr;
  assign shA[0]   = shSrcAddr;
  assign shA[1]   = shDstAddr;
  assign llA[0]   = llSrcAddr;
  assign llA[1]   = llDstAddr;
  assign curSrcAddr = curA[0];
  assign curDstAddr = curA[1];

  mblk_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .chanEn     (chanEn),
    .srcType    (sideKind_t'(srcType)),
    .dstType    (sideKind_t'(dstType)),
    .blockDone  (blockDone),
    .shValid    (shValid),
    .llAck      (llAck),
    .llValid    (llValid),
    .st         (strobe),
    .blockStart (blockStart),
    .xferDone   (xferDone),
    .cfgErr     (cfgErr),
    .waitValid  (waitValid),
    .llReq      (llReq),
    .inRun      (inRun)
  );

  mblk_dp #(
    .ADDR_W (ADDR_W),
    .CTL_W  (CTL_W),
    .SIZE_W (SIZE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (strobe),
    .initAddr   (initA),
    .endAddr    (endA),
    .shAddr     (shA),
    .llAddr     (llA),
    .initCtlIn  (initCtl),
    .shCtl      (shCtl),
    .llCtl      (llCtl),
    .initSizeIn (initSize),
    .shSize     (shSize),
    .llSize     (llSize),
    .curAddr    (curA),
    .curCtl     (curCtl),
    .curSize    (curSize)
  );

endmodule

// File: rtl/mblk_seq_chk.sv
`timescale 1ns/1ps
module mblk_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              chanEn,
  input logic [1:0]        srcType,
  input logic [1:0]        dstType,
  input logic              blockDone,
  input logic [ADDR_W-1:0] srcEndAddr,
  input logic [ADDR_W-1:0] curSrcAddr,
  input logic              blockStart,
  input logic              xferDone,
  input logic              cfgErr,
  input logic              waitValid,
  input logic              llReq,
  input logic              llAck,
  input logic              inRun
);

  // R3
  contig_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && chanEn && blockDone && srcType == 2'b00 && dstType == 2'b01)
    |=> (blockStart && curSrcAddr == ADDR_W'($past(srcEndAddr) + ADDR_W'(1))));

  // R10
  done_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && chanEn && blockDone && srcType == 2'b00 && dstType == 2'b00)
    |=> (xferDone && !blockStart));

  // R10
  done_start_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(xferDone && blockStart));

  // R11
  bad_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !$past(chanEn) && srcType == 2'b00 && dstType == 2'b00)
    |=> (cfgErr && !blockStart));

  // R11
  err_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !blockStart);

  // R6
  wait_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitValid |-> !blockStart);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (llReq && !llAck && chanEn) |=> llReq);

  // R12
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (!llReq && !waitValid && !cfgErr && !blockStart));

endmodule

bind mblk_seq mblk_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chanEn     (chanEn),
  .srcType    (srcType),
  .dstType    (dstType),
  .blockDone  (blockDone),
  .srcEndAddr (srcEndAddr),
  .curSrcAddr (curSrcAddr),
  .blockStart (blockStart),
  .xferDone   (xferDone),
  .cfgErr     (cfgErr),
  .waitValid  (waitValid),
  .llReq      (llReq),
  .llAck      (llAck),
  .inRun      (inRun)
);

// File: tb/mblk_seq_tb.sv
`timescale 1ns/1ps
module mblk_seq_tb;

  localparam int ADDR_W = 32;
  localparam int CTL_W  = 16;
  localparam int SIZE_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEn = 1'b0;
  logic [1:0] srcType = 2'b00, dstType = 2'b00;
  logic [ADDR_W-1:0] initSrcAddr = '0, initDstAddr = '0;
  logic [CTL_W-1:0]  initCtl = '0;
  logic [SIZE_W-1:0] initSize = '0;
  logic blockDone = 1'b0;
  logic [ADDR_W-1:0] srcEndAddr = '0, dstEndAddr = '0;
  logic shValid = 1'b0;
  logic [ADDR_W-1:0] shSrcAddr = '0, shDstAddr = '0;
  logic [CTL_W-1:0]  shCtl = '0;
  logic [SIZE_W-1:0] shSize = '0;
  logic llReq;
  logic llAck = 1'b0, llValid = 1'b0;
  logic [ADDR_W-1:0] llSrcAddr = '0, llDstAddr = '0;
  logic [CTL_W-1:0]  llCtl = '0;
  logic [SIZE_W-1:0] llSize = '0;
  logic [ADDR_W-1:0] curSrcAddr, curDstAddr;
  logic [CTL_W-1:0]  curCtl;
  logic [SIZE_W-1:0] curSize;
  logic blockStart, xferDone, cfgErr, waitValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mblk_seq #(.ADDR_W(ADDR_W), .CTL_W(CTL_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .srcType(srcType), .dstType(dstType),
    .initSrcAddr(initSrcAddr), .initDstAddr(initDstAddr), .initCtl(initCtl),
    .initSize(initSize), .blockDone(blockDone), .srcEndAddr(srcEndAddr),
    .dstEndAddr(dstEndAddr), .shValid(shValid), .shSrcAddr(shSrcAddr),
    .shDstAddr(shDstAddr), .shCtl(shCtl), .shSize(shSize), .llReq(llReq),
    .llAck(llAck), .llValid(llValid), .llSrcAddr(llSrcAddr), .llDstAddr(llDstAddr),
    .llCtl(llCtl), .llSize(llSize), .curSrcAddr(curSrcAddr), .curDstAddr(curDstAddr),
    .curCtl(curCtl), .curSize(curSize), .blockStart(blockStart), .xferDone(xferDone),
    .cfgErr(cfgErr), .waitValid(waitValid)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic enableCh(input logic [1:0] s, input logic [1:0] d);
    @(negedge clk);
    srcType = s; dstType = d; chanEn = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic endBlock(input logic [ADDR_W-1:0] se, input logic [ADDR_W-1:0] de);
    @(negedge clk);
    srcEndAddr = se; dstEndAddr = de; blockDone = 1'b1;
    @(posedge clk); #1;
    blockDone = 1'b0;
  endtask

  task automatic disableCh();
    @(negedge clk);
    chanEn = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic llRespond(input logic v, input logic [ADDR_W-1:0] sa,
                           input logic [ADDR_W-1:0] da, input logic [CTL_W-1:0] c,
                           input logic [SIZE_W-1:0] z);
    @(negedge clk);
    llAck = 1'b1; llValid = v; llSrcAddr = sa; llDstAddr = da; llCtl = c; llSize = z;
    @(posedge clk); #1;
    llAck = 1'b0;
  endtask

  task automatic testReset();
    step();
    chk("R1", "blockStart in reset", blockStart, 0);
    chk("R1", "cfgErr in reset", cfgErr, 0);
    chk("R1", "llReq in reset", llReq, 0);
    @(negedge clk); rstN = 1'b1;
    step();
    chk("R1", "xferDone after reset", xferDone, 0);
    chk("R1", "waitValid after reset", waitValid, 0);
    chk("R1", "curSrcAddr after reset", curSrcAddr, 0);
    chk("R1", "curSize after reset", curSize, 0);
  endtask

  task automatic testContigReload();
    initSrcAddr = 32'h0000_1000; initDstAddr = 32'h0000_2000;
    initCtl = 16'h00A5; initSize = 12'h040;
    enableCh(2'b00, 2'b01);
    chk("R2", "blockStart at enable", blockStart, 1);
    chk("R2", "curSrcAddr at enable", curSrcAddr, 32'h1000);
    chk("R2", "curDstAddr at enable", curDstAddr, 32'h2000);
    chk("R2", "curCtl at enable", curCtl, 16'h00A5);
    initSrcAddr = 32'hDEAD_0000; initDstAddr = 32'hBEEF_0000;
    initCtl = 16'hFFFF; initSize = 12'hFFF;
    step();
    chk("R2", "blockStart one cycle", blockStart, 0);
    endBlock(32'h0000_103F, 32'h0000_203F);
    chk("R3", "blockStart after block end", blockStart, 1);
    chk("R3", "contiguous source", curSrcAddr, 32'h1040);
    chk("R4", "reload destination", curDstAddr, 32'h2000);
    chk("R9", "ctl restored", curCtl, 16'h00A5);
    chk("R9", "size restored", curSize, 12'h040);
    endBlock(32'hFFFF_FFFF, 32'h0000_2010);
    chk("R3", "contiguous wrap", curSrcAddr, 32'h0);
    chk("R4", "reload ignores new init inputs", curDstAddr, 32'h2000);
    @(negedge clk); dstType = 2'b00;
    endBlock(32'h0000_0055, 32'h0000_2020);
    chk("R10", "xferDone on last block", xferDone, 1);
    chk("R10", "no blockStart on last block", blockStart, 0);
    chk("R10", "address held on last block", curSrcAddr, 32'h0);
    step();
    chk("R10", "xferDone one cycle", xferDone, 0);
    endBlock(32'h0000_0077, 32'h0000_0088);
    chk("R10", "blockDone after completion ignored", blockStart, 0);
    chk("R10", "address unchanged after completion", curSrcAddr, 32'h0);
    chk("R10", "no second xferDone", xferDone, 0);
    disableCh();
  endtask

  task automatic testBadConfig();
    enableCh(2'b00, 2'b00);
    chk("R11", "cfgErr on both contiguous", cfgErr, 1);
    chk("R11", "no blockStart on bad config", blockStart, 0);
    endBlock(32'h10, 32'h20);
    chk("R11", "cfgErr held", cfgErr, 1);
    chk("R11", "blockDone ignored in error", blockStart, 0);
    disableCh();
    chk("R12", "cfgErr cleared on disable", cfgErr, 0);
  endtask

  task automatic testShadow();
    initSrcAddr = 32'h0000_3000; initDstAddr = 32'h0000_4000;
    initCtl = 16'h0001; initSize = 12'h010;
    enableCh(2'b10, 2'b01);
    @(negedge clk);
    shValid = 1'b1; shSrcAddr = 32'h5000; shCtl = 16'h1111; shSize = 12'h111;
    endBlock(32'h3010, 32'h4010);
    chk("R5", "blockStart shadow valid", blockStart, 1);
    chk("R5", "shadow source", curSrcAddr, 32'h5000);
    chk("R5", "reload destination beside shadow", curDstAddr, 32'h4000);
    chk("R5", "ctl from shadow", curCtl, 16'h1111);
    chk("R5", "size from shadow", curSize, 12'h111);
    @(negedge clk);
    shValid = 1'b0; shSrcAddr = 32'h6000; shCtl = 16'h2222; shSize = 12'h222;
    endBlock(32'h5010, 32'h4010);
    chk("R6", "no blockStart when shadow invalid", blockStart, 0);
    chk("R6", "waitValid raised", waitValid, 1);
    step(); step();
    chk("R6", "waitValid held", waitValid, 1);
    chk("R6", "address held while waiting", curSrcAddr, 32'h5000);
    @(negedge clk); shValid = 1'b1;
    step();
    chk("R6", "blockStart on resume", blockStart, 1);
    chk("R6", "shadow source after resume", curSrcAddr, 32'h6000);
    chk("R6", "ctl after resume", curCtl, 16'h2222);
    chk("R6", "waitValid dropped", waitValid, 0);
    disableCh();
    shValid = 1'b0;
  endtask

  task automatic testLinked();
    initSrcAddr = 32'h0000_0100; initDstAddr = 32'h0000_0200;
    initCtl = 16'h0002; initSize = 12'h020;
    enableCh(2'b11, 2'b10);
    @(negedge clk);
    shValid = 1'b1; shDstAddr = 32'h7700; shCtl = 16'h3333; shSize = 12'h333;
    endBlock(32'h0110, 32'h0210);
    chk("R7", "llReq after block end", llReq, 1);
    chk("R7", "no blockStart before descriptor", blockStart, 0);
    step();
    chk("R7", "llReq held until ack", llReq, 1);
    llRespond(1'b1, 32'h8800, 32'h9900, 16'h4444, 12'h044);
    chk("R7", "blockStart on valid descriptor", blockStart, 1);
    chk("R7", "linked source", curSrcAddr, 32'h8800);
    chk("R7", "shadow destination beside linked", curDstAddr, 32'h7700);
    chk("R7", "ctl from descriptor over shadow", curCtl, 16'h4444);
    chk("R7", "size from descriptor", curSize, 12'h044);
    chk("R7", "llReq dropped", llReq, 0);
    endBlock(32'h8810, 32'h7710);
    llRespond(1'b0, 32'hBB00, 32'h0, 16'h5555, 12'h055);
    chk("R8", "waitValid on invalid descriptor", waitValid, 1);
    chk("R8", "llReq kept after invalid", llReq, 1);
    chk("R8", "no blockStart on invalid", blockStart, 0);
    chk("R8", "address held on invalid", curSrcAddr, 32'h8800);
    step();
    chk("R8", "waitValid held", waitValid, 1);
    llRespond(1'b1, 32'hAA00, 32'h0, 16'h6666, 12'h066);
    chk("R8", "blockStart on later valid", blockStart, 1);
    chk("R8", "source from later descriptor", curSrcAddr, 32'hAA00);
    chk("R8", "waitValid cleared", waitValid, 0);
    endBlock(32'hAA10, 32'h7720);
    chk("R12", "llReq pending before disable", llReq, 1);
    disableCh();
    chk("R12", "llReq cleared on disable", llReq, 0);
    chk("R12", "waitValid cleared on disable", waitValid, 0);
    chk("R12", "no blockStart on disable", blockStart, 0);
    shValid = 1'b0;
  endtask

  initial begin
    testReset();
    testContigReload();
    testBadConfig();
    testShadow();
    testLinked();
    step();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule